// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer peripheral for a slow functional clock. Software programs a reload value and a prescaler setting and then arms the counter by writing a two-word key sequence. After that, it must keep servicing the timer. While the counter runs it counts upward from the reload value. When it rolls past its all-ones value, the block issues a one-cycle reset request and starts again from the reload value. Software services the timer by writing a new value to the trigger register. That write reloads the counter and so pushes the overflow further away. A second two-word key sequence disarms the counter.

Every write to the control, reload, trigger and key registers is posted. The write is held in a per-register channel for a fixed number of cycles before it takes effect, which stands in for a clock-domain crossing. A pending register shows one busy bit per channel, so software can tell when a posted write has landed. A configuration register holds one stored bit with no side effect.

Word addresses used by the bench and software: 0 control, 1 reload, 2 trigger, 3 key (reads back the running flag in bit 0), 4 pending (read only), 5 configuration, 6 live counter (read only). Reads return data one cycle after the read address is presented.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the block is stopped, reset_req is low, and the control, reload, pending, running-flag and counter reads all return zero.
- R2: Committed key words 0xBBBB and then 0x4444, with no other key word between them, set the running flag (read bit 0 at address 3 = 1).
- R3: Committed key words 0xAAAA and then 0x5555, with no other key word between them, clear the running flag.
- R4: If a first key word is unrecognised, or the second word is not the expected partner of the first, the sequence is discarded and the running flag keeps its value.
- R5: A write to control, reload, trigger or key sets its pending bit (bit 0, 2, 3 and 4 of address 4 respectively) for POST_DLY cycles. The register keeps its old value until the bit clears. A further write while pending replaces the data and restarts the delay.
- R6: A committed trigger write whose value differs from the stored trigger value reloads the counter from the reload register. A write of the same value leaves the counter untouched.
- R7: With the prescaler off and reload value L, the counter advances by one each cycle. Consecutive reset pulses are (2^CNT_W − L) cycles apart.
- R8: Control bit 5 enables the prescaler and bits 4:2 hold its ratio p. When enabled, the counter advances once every 2^p cycles, so pulses are (2^CNT_W − L)·2^p cycles apart.
- R9: On overflow, reset_req is high for exactly one cycle and the counter restarts from the reload value.
- R10: While stopped, the counter holds its value (except on a trigger reload) and no reset request is produced.
- R11: Configuration bit 0 is stored and read back. The other configuration bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Register word address for the read |
| rd_data | output | DATA_W | Read data, registered one cycle after rd_addr |
| reset_req | output | 1 | One-cycle reset request on counter overflow |

## Verification
The overflow interval is swept over several reload distances, with the prescaler off and with ratios 0 to 4. Because the interval is the product of distance and ratio, an off-by-one in the reload, the overflow compare or the prescaler limit shows up as a wrong cycle count. Key handling is tried with both correct sequences, a lone second word, an interrupted start and an interrupted stop, which separates correct pairing from accepting any partner word. The trigger is written with a changed value and then with a repeated value while stopped, so the counter read shows whether the comparison gates the reload. Each posted register is written and read back at once and again after the delay, which shows both the pending-bit position and the deferred effect.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_KEY   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd5;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd6;

  // posted channels are the addresses 0..NUM_CH-1
  localparam int NUM_CH = 4;

  localparam logic [15:0] KEY_ARM_A    = 16'hBBBB;
  localparam logic [15:0] KEY_ARM_B    = 16'h4444;
  localparam logic [15:0] KEY_DISARM_A = 16'hAAAA;
  localparam logic [15:0] KEY_DISARM_B = 16'h5555;

  typedef enum logic [1:0] {KS_IDLE, KS_ARM, KS_DISARM} key_st_e;
endpackage

// File: rtl/kwd_post_chan.sv
module kwd_post_chan #(
  parameter int DATA_W = 32,
  parameter int DLY    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              fire,
  output logic [DATA_W-1:0] dout
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt;

  assign fire = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      dout <= '0;
    end else if (req) begin
      busy <= 1'b1;
      cnt  <= CW'(DLY);
      dout <= din;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import kwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [DATA_W-1:0] word,
  output logic              run
);
  key_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= KS_IDLE;
      run <= 1'b0;
    end else if (fire) begin
      unique case (st)
        KS_IDLE: begin
          if (word == DATA_W'(KEY_ARM_A))         st <= KS_ARM;
          else if (word == DATA_W'(KEY_DISARM_A)) st <= KS_DISARM;
        end
        KS_ARM: begin
          if (word == DATA_W'(KEY_ARM_B)) run <= 1'b1;
          st <= KS_IDLE;
        end
        KS_DISARM: begin
          if (word == DATA_W'(KEY_DISARM_B)) run <= 1'b0;
          st <= KS_IDLE;
        end
        default: st <= KS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic [CNT_W-1:0] load,
  input  logic             reload,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int              PRE_W   = 1 << PTV_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;
  logic             tick;

  assign pre_lim = (PRE_W'(1) << ptv) - PRE_W'(1);
  assign tick    = run && (!pre_en || (pre_cnt >= pre_lim));

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      pre_cnt <= '0;
      ovf     <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (reload) begin
        count   <= load;
        pre_cnt <= '0;
      end else begin
        if (!run || tick) pre_cnt <= '0;
        else              pre_cnt <= pre_cnt + PRE_W'(1);
        if (tick) begin
          if (count == CNT_MAX) begin
            count <= load;
            ovf   <= 1'b1;
          end else begin
            count <= count + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int POST_DLY = 3,
  parameter int PTV_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req
);
  localparam int CTRL_W   = PTV_W + 3;
  localparam int PRE_BIT  = PTV_W + 2;
  localparam int PEND_W   = 5;

  logic [NUM_CH-1:0] ch_req, ch_busy, ch_fire;
  logic [DATA_W-1:0] ch_data [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign ch_req[g] = wr_en && (wr_addr == ADDR_W'(g));
    kwd_post_chan #(.DATA_W(DATA_W), .DLY(POST_DLY)) i_chan (
      .clk  (clk),
      .rst  (rst),
      .req  (ch_req[g]),
      .din  (wr_data),
      .busy (ch_busy[g]),
      .fire (ch_fire[g]),
      .dout (ch_data[g])
    );
  end

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [DATA_W-1:0] trig_q;
  logic              cfg_q;
  logic              run_q;
  logic              reload;
  logic [CNT_W-1:0]  count;
  logic              ovf;
  logic [PEND_W-1:0] pend;
  logic [DATA_W-1:0] rd_mux;

  assign reload = ch_fire[A_TRIG] && (ch_data[A_TRIG] != trig_q);
  assign pend   = {ch_busy[A_KEY], ch_busy[A_TRIG], ch_busy[A_LOAD], 1'b0, ch_busy[A_CTRL]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
      cfg_q  <= 1'b0;
    end else begin
      if (ch_fire[A_CTRL]) ctrl_q <= ch_data[A_CTRL][CTRL_W-1:0];
      if (ch_fire[A_LOAD]) load_q <= ch_data[A_LOAD][CNT_W-1:0];
      if (ch_fire[A_TRIG]) trig_q <= ch_data[A_TRIG];
      if (wr_en && wr_addr == A_CFG) cfg_q <= wr_data[0];
    end
  end

  kwd_key_seq #(.DATA_W(DATA_W)) i_keys (
    .clk  (clk),
    .rst  (rst),
    .fire (ch_fire[A_KEY]),
    .word (ch_data[A_KEY]),
    .run  (run_q)
  );

  kwd_counter #(.CNT_W(CNT_W), .PTV_W(PTV_W)) i_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .pre_en (ctrl_q[PRE_BIT]),
    .ptv    (ctrl_q[PRE_BIT-1:2]),
    .load   (load_q),
    .reload (reload),
    .count  (count),
    .ovf    (ovf)
  );

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_mux = DATA_W'(ctrl_q);
      A_LOAD:  rd_mux = DATA_W'(load_q);
      A_TRIG:  rd_mux = trig_q;
      A_KEY:   rd_mux = DATA_W'(run_q);
      A_PEND:  rd_mux = DATA_W'(pend);
      A_CFG:   rd_mux = DATA_W'(cfg_q);
      A_COUNT: rd_mux = DATA_W'(count);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      reset_req <= 1'b0;
    end else begin
      rd_data   <= rd_mux;
      reset_req <= ovf;
    end
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             run,
  input logic             reload,
  input logic             key_fire,
  input logic [CNT_W-1:0] count,
  input logic [4:0]       pend,
  input logic             reset_req
);
  AST_CTRL_POSTED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0) |=> pend[0]); // R5

  AST_KEY_POSTED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd3) |=> pend[4]); // R5

  AST_RUN_BY_KEY_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(run) |-> $past(key_fire)); // R4

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !reload) |=> $stable(count)); // R10

  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> $past(run, 2)); // R10

  AST_PEND_BIT1_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pend[1]); // R5
endmodule

bind keyed_wdt kwd_checker #(.CNT_W(CNT_W)) i_kwd_checker (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .run       (run_q),
  .reload    (reload),
  .key_fire  (ch_fire[3]),
  .count     (count),
  .pend      (pend),
  .reset_req (reset_req)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int DLY = 3;
  localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        reset_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [31:0] tv = 32'h1234;

  always #10 clk = ~clk;

  keyed_wdt #(.POST_DLY(DLY)) i_keyed_wdt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .reset_req(reset_req)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (DLY + 1) @(negedge clk);
  endtask

  task automatic wrs(logic [2:0] a, logic [31:0] d);
    wr(a, d);
    settle();
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic start_run();
    wrs(3'd3, 32'hBBBB); wrs(3'd3, 32'h4444);
  endtask

  task automatic stop_run();
    wrs(3'd3, 32'hAAAA); wrs(3'd3, 32'h5555);
  endtask

  task automatic new_trig();
    tv = tv + 32'd1;
    wrs(3'd2, tv);
  endtask

  task automatic period(int k, bit en, int p, string rq);
    int n;
    int exp;
    bit seen;
    stop_run();
    wrs(3'd0, {26'd0, en, 3'(p), 2'b00});
    wrs(3'd1, MAXV - 32'(k) + 32'd1);
    new_trig();
    start_run();
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (reset_req) seen = 1;
    end
    n = 0;
    exp = en ? (k << p) : k;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      n++;
      if (n == 1) chk("R9 pulse width", 32'(reset_req), 32'd0);
      if (reset_req) break;
    end
    chk(rq, 32'(n), 32'(exp));
  endtask

  initial begin
    logic [31:0] d, d2;
    bit pulse;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset_req", 32'(reset_req), 32'd0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 load", d, 0);
    rd(3'd4, d); chk("R1 pend", d, 0);
    rd(3'd3, d); chk("R1 run", d, 0);
    rd(3'd6, d); chk("R1 count", d, 0);

    // R11 config bit
    wr(3'd5, 32'hFF); rd(3'd5, d); chk("R11 cfg set", d, 1);
    wr(3'd5, 32'h0);  rd(3'd5, d); chk("R11 cfg clr", d, 0);

    // R5 posted writes and pending bit positions
    wr(3'd1, 32'h55); rd(3'd4, d); chk("R5 pend load", d, 32'h4);
    rd(3'd1, d); chk("R5 load not yet", d, 0);
    settle(); rd(3'd4, d); chk("R5 pend clear", d, 0);
    rd(3'd1, d); chk("R5 load landed", d, 32'h55);
    wr(3'd0, 32'h0); rd(3'd4, d); chk("R5 pend ctrl", d, 32'h1); settle();
    tv = tv + 1;
    wr(3'd2, tv);    rd(3'd4, d); chk("R5 pend trig", d, 32'h8); settle();
    wr(3'd3, 32'h0); rd(3'd4, d); chk("R5 pend key", d, 32'h10); settle();
    wr(3'd1, 32'h66); @(negedge clk); wr(3'd1, 32'h77);
    rd(3'd4, d); chk("R5 rewrite pending", d, 32'h4);
    settle(); rd(3'd1, d); chk("R5 rewrite value", d, 32'h77);

    // R2 / R3 / R4 key sequences
    start_run(); rd(3'd3, d); chk("R2 start", d, 1);
    stop_run();  rd(3'd3, d); chk("R3 stop", d, 0);
    wrs(3'd3, 32'h4444); rd(3'd3, d); chk("R4 lone second", d, 0);
    wrs(3'd3, 32'hBBBB); wrs(3'd3, 32'h1234); wrs(3'd3, 32'h4444);
    rd(3'd3, d); chk("R4 broken start", d, 0);
    wrs(3'd3, 32'hBBBB); wrs(3'd3, 32'h5555);
    rd(3'd3, d); chk("R4 wrong partner", d, 0);
    start_run();
    wrs(3'd3, 32'hAAAA); wrs(3'd3, 32'h1111); wrs(3'd3, 32'h5555);
    rd(3'd3, d); chk("R4 broken stop", d, 1);
    stop_run();

    // R6 trigger compare
    wrs(3'd1, 32'd100); new_trig();
    rd(3'd6, d); chk("R6 new trig reload", d, 100);
    wrs(3'd1, 32'd200); wrs(3'd2, tv);
    rd(3'd6, d); chk("R6 same trig no reload", d, 100);
    rd(3'd2, d); chk("R6 trig readback", d, tv);
    new_trig(); rd(3'd6, d); chk("R6 changed trig", d, 200);

    // R10 stopped: hold and no pulse
    wrs(3'd0, 32'h0); wrs(3'd1, MAXV); new_trig();
    rd(3'd6, d); repeat (20) @(negedge clk); rd(3'd6, d2);
    chk("R10 count held", d2, d);
    pulse = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (reset_req) pulse = 1;
    end
    chk("R10 no pulse", 32'(pulse), 0);

    // R7 prescaler off
    period(2, 0, 5, "R7 period k=2");
    period(5, 0, 0, "R7 period k=5");
    period(10, 0, 7, "R7 period k=10");
    // R8 prescaler sweep
    for (int p = 0; p <= 4; p++) begin
      period(2, 1, p, "R8 period k=2");
      period(5, 1, p, "R8 period k=5");
    end

    stop_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule